// File: doc/BRIEF.md
# Almost-Flag Offset Register

This block keeps the two threshold offsets that a FIFO uses for its partial status flags, and turns the current occupancy into an almost-empty flag and an almost-full flag. The read side supplies how many words are stored. The write side supplies the same count as it sees it. The block compares each count against its own offset and registers the result.

A master reset loads both offsets with one of two preset values. A select input, sampled only while master reset is high, picks the preset. After reset the offsets can be rewritten in either of two ways:

- Parallel: whole words come from the data bus under a load strobe.
- Serial: one bit per clock comes from a serial input while a serial enable is high.

A partial reset empties the flags and restarts both loading sequences, but keeps the programmed offsets. The FIFO storage and any crossing between clock domains are outside the block. Both occupancy counts arrive already synchronised to the single block clock.

Top module: `almost_flag_offsets`

## Requirements
- R1: In the clock after a master reset edge, both offsets equal 7 when `preset_sel` was 0 at that edge, and both equal 63 when it was 1.
- R2: Outside master reset, `preset_sel` has no effect on either offset.
- R3: `almost_empty` is 1 exactly when `rd_level` is less than or equal to the almost-empty offset. It is registered, so it reflects the inputs of the previous clock edge. A level of 0 always gives 1.
- R4: `almost_full` is 1 exactly when the free space, DEPTH minus `wr_level`, is less than or equal to the almost-full offset. It is registered. A level of DEPTH always gives 1.
- R5: Each clock with `par_load` high writes `par_data` into the next slot of a cyclic sequence. The sequence runs through the almost-empty offset first and then the almost-full offset, low part before high part. The offset takes bits [OFS_W-1:0] of the bus, so with the default widths the top bus bit is ignored, one write fills one offset, and the third write returns to the almost-empty offset.
- R6: Each clock with `ser_en` high and `par_load` low writes `ser_data` into the next bit of a cyclic 2*OFS_W-bit sequence. The sequence fills the almost-empty offset from bit 0 upward and then the almost-full offset from bit 0 upward.
- R7: When `par_load` and `ser_en` are both high, only the parallel write happens. The serial bit is dropped and the serial position does not advance.
- R8: A partial reset keeps both offsets, restarts the parallel and serial sequences at their first slot, and sets `almost_empty` to 1 and `almost_full` to 0 in the following clock.
- R9: Master reset takes priority over partial reset. When both are high, the offsets take the preset values.
- R10: In the clock after any master reset edge, `almost_empty` is 1 and `almost_full` is 0, whatever the levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| preset_sel | input | 1 | Chooses the preset pair during master reset (0: 7, 1: 63) |
| par_load | input | 1 | Strobe for a parallel offset write |
| par_data | input | BUS_W | Parallel write data |
| ser_en | input | 1 | Enables one serial bit write per clock |
| ser_data | input | 1 | Serial write bit |
| rd_level | input | LVL_W | Occupancy as seen by the read side |
| wr_level | input | LVL_W | Occupancy as seen by the write side |
| almost_empty | output | 1 | Registered almost-empty flag |
| almost_full | output | 1 | Registered almost-full flag |

## Verification
A write of an offset, by either method, takes effect at the edge where it is sampled. The flags register their comparison one edge later. The bench therefore writes offsets with the level inputs idle, and probes each threshold in a later cycle. A probe sets a level at the falling edge and reads the flag one nanosecond after the next rising edge. Each offset is measured as a boundary pair: at the threshold the flag must be 1, and one step past it the flag must be 0. Reset effects on the flags are read right after the reset edge itself.

// File: rtl/afr_pkg.sv
package afr_pkg;

    localparam int AFR_DEPTH_DEF  = 128;
    localparam int AFR_BUS_W_DEF  = 9;
    localparam int AFR_PRESET_LO  = 7;
    localparam int AFR_PRESET_HI  = 63;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_PAR  = 2'd1,
        LD_SER  = 2'd2
    } ld_mode_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int preset_ofs(input logic sel);
        return sel ? AFR_PRESET_HI : AFR_PRESET_LO;
    endfunction

endpackage

// File: rtl/afr_ofs_bank.sv
module afr_ofs_bank
    import afr_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int BUS_W = 9
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             fsel,
    input  logic             ld,
    input  logic [BUS_W-1:0] din,
    input  logic             ser_en,
    input  logic             ser_din,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam int WPO    = ceil_div(OFS_W, BUS_W);
    localparam int PSLOTS = 2 * WPO;
    localparam int SSLOTS = 2 * OFS_W;
    localparam int PIDX_W = (PSLOTS > 1) ? $clog2(PSLOTS) : 1;
    localparam int SIDX_W = $clog2(SSLOTS);

    logic [1:0][OFS_W-1:0] ofs_q, ofs_d;
    logic [PIDX_W-1:0]     par_idx, par_nxt;
    logic [SIDX_W-1:0]     ser_idx, ser_nxt;
    ld_mode_e              mode;

    generate
        if (OFS_W < BUS_W) begin : g_spare
            logic unused_din_hi;
            assign unused_din_hi = ^din[BUS_W-1:OFS_W];
        end
    endgenerate

    always_comb begin
        if (ld)          mode = LD_PAR;
        else if (ser_en) mode = LD_SER;
        else             mode = LD_IDLE;
    end

    always_comb begin
        ofs_d   = ofs_q;
        par_nxt = par_idx;
        ser_nxt = ser_idx;
        case (mode)
            LD_PAR: begin
                for (int s = 0; s < 2; s++) begin
                    for (int b = 0; b < OFS_W; b++) begin
                        if (s * WPO + b / BUS_W == int'(par_idx))
                            ofs_d[s][b] = din[b % BUS_W];
                    end
                end
                par_nxt = (int'(par_idx) == PSLOTS - 1) ? '0 : par_idx + 1'b1;
            end
            LD_SER: begin
                for (int s = 0; s < 2; s++) begin
                    for (int b = 0; b < OFS_W; b++) begin
                        if (s * OFS_W + b == int'(ser_idx))
                            ofs_d[s][b] = ser_din;
                    end
                end
                ser_nxt = (int'(ser_idx) == SSLOTS - 1) ? '0 : ser_idx + 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            ofs_q   <= {2{OFS_W'(preset_ofs(fsel))}};
            par_idx <= '0;
            ser_idx <= '0;
        end else if (prst) begin
            par_idx <= '0;
            ser_idx <= '0;
        end else begin
            ofs_q   <= ofs_d;
            par_idx <= par_nxt;
            ser_idx <= ser_nxt;
        end
    end

    assign ae_ofs = ofs_q[0];
    assign af_ofs = ofs_q[1];

    // R1 R9
    preset_load_chk: assert property (@(posedge clk)
        mrst |=> (ae_ofs == OFS_W'(preset_ofs($past(fsel)))) &&
                 (af_ofs == OFS_W'(preset_ofs($past(fsel)))));

    // R8
    prst_keeps_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> $stable(ofs_q));

    // R6
    serial_one_bit_chk: assert property (@(posedge clk) disable iff (mrst)
        (ser_en && !ld && !prst) |=> ($countones(ofs_q ^ $past(ofs_q)) <= 1));

    // R7
    par_over_ser_chk: assert property (@(posedge clk) disable iff (mrst)
        (ld && !prst) |=> $stable(ser_idx));

endmodule

// File: rtl/afr_flag_cmp.sv
module afr_flag_cmp #(
    parameter int LVL_W    = 8,
    parameter int DEPTH    = 128,
    parameter bit FROM_TOP = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] ofs,
    output logic             flag
);
    localparam logic RST_VAL = !FROM_TOP;

    logic [LVL_W-1:0] measure;
    logic [LVL_W-1:0] edge_level;

    generate
        if (FROM_TOP) begin : g_space
            assign measure    = LVL_W'(DEPTH) - level;
            assign edge_level = LVL_W'(DEPTH);
        end else begin : g_fill
            assign measure    = level;
            assign edge_level = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flag <= RST_VAL;
        else     flag <= (measure <= ofs);
    end

    // R3 R4
    extreme_level_chk: assert property (@(posedge clk) disable iff (rst)
        (level == edge_level) |=> flag);

    // R8 R10
    flag_reset_chk: assert property (@(posedge clk)
        rst |=> (flag == RST_VAL));

endmodule

// File: rtl/almost_flag_offsets.sv
module almost_flag_offsets
    import afr_pkg::*;
#(
    parameter int  DEPTH = AFR_DEPTH_DEF,
    parameter int  BUS_W = AFR_BUS_W_DEF,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             mrst,
    input  logic             prst,
    input  logic             preset_sel,
    input  logic             par_load,
    input  logic [BUS_W-1:0] par_data,
    input  logic             ser_en,
    input  logic             ser_data,
    input  logic [LVL_W-1:0] rd_level,
    input  logic [LVL_W-1:0] wr_level,
    output logic             almost_empty,
    output logic             almost_full
);
    logic [LVL_W-1:0] ae_ofs, af_ofs;
    logic             flag_rst;

    assign flag_rst = mrst | prst;

    afr_ofs_bank #(.OFS_W(LVL_W), .BUS_W(BUS_W)) u_bank (
        .clk     (clk),
        .mrst    (mrst),
        .prst    (prst),
        .fsel    (preset_sel),
        .ld      (par_load),
        .din     (par_data),
        .ser_en  (ser_en),
        .ser_din (ser_data),
        .ae_ofs  (ae_ofs),
        .af_ofs  (af_ofs)
    );

    afr_flag_cmp #(.LVL_W(LVL_W), .DEPTH(DEPTH), .FROM_TOP(1'b0)) u_ae (
        .clk   (clk),
        .rst   (flag_rst),
        .level (rd_level),
        .ofs   (ae_ofs),
        .flag  (almost_empty)
    );

    afr_flag_cmp #(.LVL_W(LVL_W), .DEPTH(DEPTH), .FROM_TOP(1'b1)) u_af (
        .clk   (clk),
        .rst   (flag_rst),
        .level (wr_level),
        .ofs   (af_ofs),
        .flag  (almost_full)
    );

    // R8
    prst_flags_chk: assert property (@(posedge clk) disable iff (mrst)
        prst |=> (almost_empty && !almost_full));

endmodule

// File: tb/almost_flag_offsets_test.sv
`timescale 1ns/1ps
module almost_flag_offsets_test;
    localparam int DEPTH = 128;
    localparam int BUS_W = 9;
    localparam int LVL_W = 8;

    logic             clk = 1'b0;
    logic             mrst = 1'b1, prst = 1'b0, preset_sel = 1'b0;
    logic             par_load = 1'b0, ser_en = 1'b0, ser_data = 1'b0;
    logic [BUS_W-1:0] par_data = '0;
    logic [LVL_W-1:0] rd_level = '0, wr_level = '0;
    logic             almost_empty, almost_full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    almost_flag_offsets #(.DEPTH(DEPTH), .BUS_W(BUS_W)) uut (
        .clk(clk), .mrst(mrst), .prst(prst), .preset_sel(preset_sel),
        .par_load(par_load), .par_data(par_data), .ser_en(ser_en),
        .ser_data(ser_data), .rd_level(rd_level), .wr_level(wr_level),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic sample_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic probe_ae(input int v, input string tag);
        @(negedge clk); rd_level = LVL_W'(v);
        sample_edge(); check(almost_empty, 1'b1, {tag, " ae at offset"});
        @(negedge clk); rd_level = LVL_W'(v + 1);
        sample_edge(); check(almost_empty, 1'b0, {tag, " ae above offset"});
    endtask

    task automatic probe_af(input int v, input string tag);
        @(negedge clk); wr_level = LVL_W'(DEPTH - v);
        sample_edge(); check(almost_full, 1'b1, {tag, " af at offset"});
        @(negedge clk); wr_level = LVL_W'(DEPTH - v - 1);
        sample_edge(); check(almost_full, 1'b0, {tag, " af above offset"});
    endtask

    task automatic do_mrst(input logic sel);
        @(negedge clk);
        mrst = 1'b1; preset_sel = sel;
        rd_level = LVL_W'(100); wr_level = LVL_W'(DEPTH);
        sample_edge();
        check(almost_empty, 1'b1, "R10 ae after master reset");
        check(almost_full, 1'b0, "R10 af after master reset");
        @(negedge clk);
        mrst = 1'b0; preset_sel = ~sel;
        rd_level = '0; wr_level = '0;
    endtask

    task automatic par_write(input logic [BUS_W-1:0] d);
        @(negedge clk); par_load = 1'b1; par_data = d;
        @(negedge clk); par_load = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ser_en = 1'b1; ser_data = v[i];
        end
        @(negedge clk); ser_en = 1'b0;
    endtask

    task automatic t_defaults();
        do_mrst(1'b0);
        repeat (4) @(negedge clk);
        probe_ae(7, "R1 R2 sel0");
        probe_af(7, "R1 R2 sel0");
        do_mrst(1'b1);
        probe_ae(63, "R1 R2 sel1");
        probe_af(63, "R1 R2 sel1");
    endtask

    task automatic t_level_edges();
        do_mrst(1'b0);
        @(negedge clk); rd_level = '0; wr_level = LVL_W'(DEPTH);
        sample_edge();
        check(almost_empty, 1'b1, "R3 ae at level 0");
        check(almost_full, 1'b1, "R4 af at level DEPTH");
        @(negedge clk); rd_level = LVL_W'(DEPTH); wr_level = '0;
        sample_edge();
        check(almost_empty, 1'b0, "R3 ae at level DEPTH");
        check(almost_full, 1'b0, "R4 af at level 0");
    endtask

    task automatic t_parallel();
        do_mrst(1'b0);
        par_write(9'h114);
        par_write(9'h064);
        probe_ae(20, "R5 first write, bus bit 8 ignored");
        probe_af(100, "R5 second write");
        par_write(9'h01E);
        probe_ae(30, "R5 third write wraps");
        probe_af(100, "R5 af kept on wrap");
    endtask

    task automatic t_serial();
        do_mrst(1'b0);
        shift_bits((32'd90 << 8) | 32'd53, 16);
        probe_ae(53, "R6 serial ae");
        probe_af(90, "R6 serial af");
    endtask

    task automatic t_priority();
        do_mrst(1'b0);
        @(negedge clk);
        par_load = 1'b1; par_data = 9'h010; ser_en = 1'b1; ser_data = 1'b1;
        @(negedge clk);
        par_load = 1'b0; ser_en = 1'b0;
        shift_bits(32'd40, 8);
        probe_ae(40, "R7 serial position held");
        probe_af(7, "R7 af untouched");
    endtask

    task automatic t_partial();
        do_mrst(1'b0);
        par_write(9'h019);
        @(negedge clk);
        prst = 1'b1; rd_level = LVL_W'(100); wr_level = LVL_W'(DEPTH);
        sample_edge();
        check(almost_empty, 1'b1, "R8 ae after partial reset");
        check(almost_full, 1'b0, "R8 af after partial reset");
        @(negedge clk); prst = 1'b0; rd_level = '0; wr_level = '0;
        probe_ae(25, "R8 ae kept");
        par_write(9'h021);
        probe_ae(33, "R8 parallel restart");
        probe_af(7, "R8 af kept");
        shift_bits(32'h7, 3);
        @(negedge clk); prst = 1'b1;
        @(negedge clk); prst = 1'b0;
        shift_bits(32'd9, 8);
        probe_ae(9, "R8 serial restart");
    endtask

    task automatic t_mrst_wins();
        do_mrst(1'b0);
        par_write(9'h014);
        @(negedge clk); mrst = 1'b1; prst = 1'b1; preset_sel = 1'b1;
        @(negedge clk); mrst = 1'b0; prst = 1'b0; preset_sel = 1'b0;
        probe_ae(63, "R9 master over partial");
        probe_af(63, "R9 master over partial");
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_defaults();
        t_level_edges();
        t_parallel();
        t_serial();
        t_priority();
        t_partial();
        t_mrst_wins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule